// File: doc/BRIEF.md
# Serial Flash Status Guard

This block is the command front end of a serial NOR flash that handles only the status register and its write protection. It watches the four SPI mode-0 slave lines and the active-low write-protect input. After chip select goes low it collects one command byte. Four opcodes are recognised: set the write-enable latch, clear it, read the status byte, and write the status byte. A rejected or unknown command sends the front end into a standby state. In that state it drives nothing and treats every later byte as noise until chip select falls again. Array read, program and erase are handled elsewhere.

The status byte has two live bits. Bit 1 is the write-enable latch. Bit 7 is the status-lock bit. When the lock bit is set and the protect pin is held low, the status register is frozen. The `DATA_BYTES` parameter selects the one-byte or two-byte form of the write-status command. The two-byte form also carries a quad-enable bit, which is brought out on its own pin.

All SPI inputs and the protect pin are resynchronised into the block clock, which must run several times faster than the serial clock.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset the write-enable latch, the status-lock bit and `quad_en` are all 0, `miso_oe` is 0 and `miso` is 1.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either change can be seen through a later status read.
- R3: Opcode 0x05 raises `miso_oe` and shifts out the status byte MSB first: the lock bit at bit 7, the write-enable latch at bit 1, and 0 in every other bit. It sends the byte again for every further byte clocked while chip select stays low.
- R4: An accepted write-status (opcode 0x01) takes the new lock bit from bit 7 of the first data byte. The new value takes effect at the chip-select rising edge that ends the command, and the write-enable latch clears at that same edge.
- R5: A write-status issued while the write-enable latch is clear is refused, and the status byte and `quad_en` keep their values.
- R6: A write-status is refused when the lock bit is 1 and `wp_n` is low at the moment the command byte completes. Every other combination of the two is accepted, whatever `wp_n` does after the command byte.
- R7: An unknown opcode or a refused write-status puts the block in standby. In standby `miso_oe` is 0, every byte reads back as 0xFF, and no later byte in the same selection is decoded (a trailing 0x06 does not set the latch).
- R8: Standby ends at the next chip-select falling edge, and the command byte that follows is decoded normally.
- R9: With `DATA_BYTES` = 2, bit 1 of the second data byte of an accepted write-status sets `quad_en`. With `DATA_BYTES` = 1, `quad_en` stays 0.
- R10: A write-status whose selection ends before all its data bytes have arrived changes nothing, and the write-enable latch stays set.
- R11: A selection that ends before eight command bits have been clocked decodes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Active-low write-protect pin |
| miso | output | 1 | Serial data out; 1 when not driving |
| miso_oe | output | 1 | High while the device drives `miso` |
| quad_en | output | 1 | Quad-enable bit from the status write |

## Verification
The bench targets the point at which the protect pin is sampled. If the pin were read at deselect rather than at the end of the command byte, the directed case that drops `wp_n` after the opcode would wrongly freeze the register. It sends trailing bytes after refused and unknown commands, including a trailing write-enable. A design that re-decodes bytes in standby would then show a set latch, or would drive `miso` with something other than ones. Write-status selections cut short after one data byte, and command bytes cut off mid-byte, would expose a design that commits early: the lock bit would change or the latch would be lost. Random sequences then mix all of these against a bench model of the latch, the lock bit and the quad bit.

// File: rtl/spi_sr_guard.sv
module spi_sr_guard #(
  parameter int DATA_BYTES = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRDI = 8'h04,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_WRSR = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe,
  output logic quad_en
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_READ, S_WDATA, S_HOLD, S_STBY} st_t;

  logic [LAST:0] sck_p, cs_p, mosi_p, wp_p;
  logic sck_s, cs_s, mosi_s, wp_s;
  logic sck_d, cs_d;
  logic sck_rise, sck_fall, cs_rise, cs_fall;

  st_t        state;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] tx;
  logic [7:0] rx;
  logic [7:0] status;
  logic       wel, srwd, qe;
  logic       new_srwd, new_qe, commit, didx;
  logic       wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      wp_p   <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_p  <= {sck_p[LAST-1:0], sck};
      cs_p   <= {cs_p[LAST-1:0], cs_n};
      mosi_p <= {mosi_p[LAST-1:0], mosi};
      wp_p   <= {wp_p[LAST-1:0], wp_n};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  assign sck_s    = sck_p[LAST];
  assign cs_s     = cs_p[LAST];
  assign mosi_s   = mosi_p[LAST];
  assign wp_s     = wp_p[LAST];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign cs_fall  = ~cs_s & cs_d;

  assign rx      = {shreg, mosi_s};
  assign status  = {srwd, 5'b0, wel, 1'b0};
  assign wr_open = (state == S_WDATA);
  assign miso_oe = (state == S_READ);
  assign miso    = miso_oe ? tx[7] : 1'b1;
  assign quad_en = qe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '1;
      wel      <= 1'b0;
      srwd     <= 1'b0;
      qe       <= 1'b0;
      new_srwd <= 1'b0;
      new_qe   <= 1'b0;
      commit   <= 1'b0;
      didx     <= 1'b0;
    end else if (cs_rise) begin
      if (state == S_HOLD && commit) begin
        srwd <= new_srwd;
        qe   <= new_qe;
        wel  <= 1'b0;
      end
      commit <= 1'b0;
      state  <= S_IDLE;
    end else if (cs_fall) begin
      state  <= S_CMD;
      bitcnt <= '0;
      didx   <= 1'b0;
      commit <= 1'b0;
    end else if (!cs_s && sck_rise && state != S_IDLE && state != S_STBY) begin
      shreg  <= rx[6:0];
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd7) begin
        case (state)
          S_CMD: begin
            if (rx == OP_WREN) begin
              wel   <= 1'b1;
              state <= S_HOLD;
            end else if (rx == OP_WRDI) begin
              wel   <= 1'b0;
              state <= S_HOLD;
            end else if (rx == OP_RDSR) begin
              tx    <= status;
              state <= S_READ;
            end else if (rx == OP_WRSR) begin
              if (wel && !(!wp_s && srwd)) begin
                state  <= S_WDATA;
                didx   <= 1'b0;
                new_qe <= qe;
              end else begin
                state <= S_STBY;
              end
            end else begin
              state <= S_STBY;
            end
          end
          S_READ: tx <= status;
          S_WDATA: begin
            if (!didx) begin
              new_srwd <= rx[7];
              if (DATA_BYTES == 1) begin
                commit <= 1'b1;
                state  <= S_HOLD;
              end else begin
                didx <= 1'b1;
              end
            end else begin
              new_qe <= rx[1];
              commit <= 1'b1;
              state  <= S_HOLD;
            end
          end
          default: ;
        endcase
      end
    end else if (sck_fall && state == S_READ && bitcnt != 3'd0) begin
      tx <= {tx[6:0], 1'b1};
    end
  end

endmodule

module sr_guard_props (
  input logic clk,
  input logic rst_n,
  input logic miso,
  input logic miso_oe,
  input logic wel,
  input logic srwd,
  input logic wp_s,
  input logic cs_rise,
  input logic wr_open
);

  p_quiet_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> miso);

  p_lock_at_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd != $past(srwd)) |-> $past(cs_rise));

  p_latch_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd != $past(srwd)) |-> ($past(wel) && !wel));

  p_open_needs_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |-> wel);

  p_hw_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_open && !$past(wr_open)) |-> !(!$past(wp_s) && $past(srwd)));

  p_no_drive_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |-> !miso_oe);

endmodule

bind spi_sr_guard sr_guard_props u_props (
  .clk(clk), .rst_n(rst_n), .miso(miso), .miso_oe(miso_oe), .wel(wel),
  .srwd(srwd), .wp_s(wp_s), .cs_rise(cs_rise), .wr_open(wr_open)
);

// File: tb/test_spi_sr_guard.sv
module test_spi_sr_guard;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe, quad_en;

  int total = 0, bad = 0;
  logic m_wel = 1'b0, m_srwd = 1'b0, m_qe = 1'b0;

  always #4 clk = ~clk;

  spi_sr_guard i_spi_sr_guard (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe), .quad_en(quad_en)
  );

  function automatic logic [7:0] exp_status();
    return {m_srwd, 5'b0, m_wel, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_n(HALF);
  endtask

  task automatic desel();
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(2 * HALF);
  endtask

  task automatic bits(input logic [7:0] tb, input int n, output logic [7:0] rb, output logic oe_any);
    rb = 8'hFF;
    oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tb[i];
      wait_n(HALF);
      rb[i] = miso;
      oe_any = oe_any | miso_oe;
      sck = 1'b1;
      wait_n(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tb, output logic [7:0] rb, output logic oe_any);
    bits(tb, 8, rb, oe_any);
  endtask

  task automatic simple(input logic [7:0] op);
    logic [7:0] r;
    logic o;
    sel();
    xfer(op, r, o);
    desel();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  task automatic read_chk(input string req, input int n);
    logic [7:0] r;
    logic o;
    sel();
    xfer(8'h05, r, o);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r, o);
      chk(req, r, exp_status());
      chk({req, " oe"}, {7'b0, o}, 8'h01);
    end
    desel();
    chk({req, " quad"}, {7'b0, quad_en}, {7'b0, m_qe});
  endtask

  // write-status with n data bytes; wp held at w through the selection
  task automatic wrsr(input string req, input logic w, input logic [7:0] d0, input logic [7:0] d1, input int n);
    logic [7:0] r;
    logic o;
    logic acc;
    wp_n = w;
    wait_n(4);
    acc = m_wel && !(!w && m_srwd);
    sel();
    xfer(8'h01, r, o);
    for (int k = 0; k < n; k++) begin
      xfer(k == 0 ? d0 : (k == 1 ? d1 : 8'h06), r, o);
      chk({req, " data byte"}, r, 8'hFF);
      chk({req, " data oe"}, {7'b0, o}, 8'h00);
    end
    desel();
    if (acc && n >= 2) begin
      m_srwd = d0[7];
      m_qe = d1[1];
      m_wel = 1'b0;
    end
    wp_n = 1'b1;
    wait_n(4);
  endtask

  task automatic junk(input logic [7:0] op, input int n);
    logic [7:0] r;
    logic o;
    sel();
    xfer(op, r, o);
    for (int k = 0; k < n; k++) begin
      xfer(8'h06, r, o);
      chk("R7 standby byte", r, 8'hFF);
      chk("R7 standby oe", {7'b0, o}, 8'h00);
    end
    desel();
  endtask

  task automatic cut(input logic [7:0] op, input int n);
    logic [7:0] r;
    logic o;
    sel();
    bits(op, n, r, o);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, op;
    logic o;
    void'($urandom(32'd9131));
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    chk("R1 miso", {7'b0, miso}, 8'h01);
    chk("R1 oe", {7'b0, miso_oe}, 8'h00);
    chk("R1 quad", {7'b0, quad_en}, 8'h00);
    read_chk("R1 status", 1);

    simple(8'h06);
    read_chk("R2 R3 latch set, repeated", 3);
    simple(8'h04);
    read_chk("R2 latch clear", 1);

    wrsr("R5 no latch", 1'b1, 8'h80, 8'h02, 3);
    read_chk("R5 unchanged", 1);

    simple(8'h06);
    wrsr("R4 R9 accepted", 1'b1, 8'h80, 8'h02, 2);
    read_chk("R4 R9 lock set", 1);

    simple(8'h06);
    wrsr("R6 hw locked", 1'b0, 8'h00, 8'h00, 3);
    read_chk("R6 refused keeps lock", 1);

    wrsr("R6 pin high unlocks", 1'b1, 8'h00, 8'h00, 2);
    read_chk("R6 lock cleared", 1);

    simple(8'h06);
    wrsr("R10 short", 1'b1, 8'h80, 8'h00, 1);
    read_chk("R10 unchanged, latch kept", 1);

    simple(8'h04);
    junk(8'h9F, 2);
    read_chk("R7 trailing byte ignored", 1);
    simple(8'h06);
    read_chk("R8 decode after standby", 1);

    simple(8'h04);
    cut(8'h06, 5);
    read_chk("R11 cut command", 1);

    // R6: pin sampled at end of command byte
    simple(8'h06);
    wrsr("R6 set lock", 1'b1, 8'h80, 8'h02, 2);
    simple(8'h06);
    sel();
    xfer(8'h01, r, o);
    wp_n = 1'b0;
    xfer(8'h00, r, o);
    xfer(8'h00, r, o);
    desel();
    wp_n = 1'b1;
    m_srwd = 1'b0; m_qe = 1'b0; m_wel = 1'b0;
    read_chk("R6 pin drop after opcode", 1);

    for (int it = 0; it < 90; it++) begin
      case ($urandom % 6)
        0: simple(8'h06);
        1: simple(8'h04);
        2: read_chk("R3 random read", 1 + int'($urandom % 3));
        3: wrsr("R4 R6 random write", 1'($urandom), 8'($urandom), 8'($urandom), int'($urandom % 4));
        4: begin
          do op = 8'($urandom); while (op == 8'h01 || op == 8'h04 || op == 8'h05 || op == 8'h06);
          junk(op, int'($urandom % 3));
        end
        default: cut(8'h06, 1 + int'($urandom % 7));
      endcase
      read_chk("R2 R4 random status", 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule